// File: doc/BRIEF.md
# Memory Dependence Wakeup Scheduler

This block holds the in-flight memory operations of an out-of-order core: loads, stores and the two kinds of memory barrier. Each one takes a slot in a small table, keyed by its sequence number and tagged with its thread. When an operation is inserted, the block decides whether it must wait for an older producer. The producer is an active barrier if one applies. Otherwise it is the producing-store sequence number that an external store-set predictor presents on `cmd_pred_seq`. A waiting operation is released when its producer completes or is removed. An operation becomes issue-ready only once it holds both a register-ready mark and a memory-ready mark. Ready operations leave the block one per cycle through a valid/ready output port.

All requests share one command port, one command per cycle. The commands are: insert, non-speculative insert, barrier insert, register-ready, non-speculative-ready, reschedule, replay, complete and squash. A reschedule places an operation on a replay list. A later replay command re-sends every listed operation, in the order the reschedules arrived. A squash removes one thread's operations that are younger than a given sequence number, both from the table and from the replay list. Releases that cannot leave at once stay pending inside the table. Pending entries are sent lowest slot first, and replayed entries take precedence over them.

Top module: `memdep_sched`

## Requirements
- R1: An insert (op 0) picks its producer as follows. A load (kind 0) uses the load-barrier sequence number while that barrier is armed. A store (kind 1) uses the store-barrier sequence number while that barrier is armed. In every other case the insert uses `cmd_pred_seq`, so barrier state overrides the prediction.
- R2: The insert has no dependence in three cases: the producer number is zero, it matches no table entry, or it matches an entry that is a load.
- R3: An insert with no dependence is marked memory-ready at once. If `cmd_regs_rdy` is also high, it is sent to the output without any further command.
- R4: A barrier insert (op 2) with kind 2 (full) arms both barriers with its sequence number. Kind 3 (write) arms only the store barrier and leaves the load barrier untouched.
- R5: Completing a barrier (op 7) disarms each barrier only if that barrier's recorded number equals the completing sequence number.
- R6: Completing a store or barrier releases every entry waiting on it. Completing or removing any entry frees its slot.
- R7: When an entry is released and its registers are ready, it is sent. Otherwise it only becomes memory-ready.
- R8: A register-ready command (op 3) sends the entry only if it is already memory-ready. Otherwise it just records the registers as ready.
- R9: A squash (op 8) with number S and thread T removes every entry of thread T whose sequence number is greater than S. Later commands naming a removed entry have no effect.
- R10: Reschedule (op 5) appends an entry to the replay list. Replay (op 6) sends every listed entry, in list order, and empties the list. A squash also drops matching entries from the list.
- R11: A non-speculative insert (op 1) skips the dependence check. Its entry is sent only by a non-speculative-ready command (op 4); register-ready commands do not send it.
- R12: With every slot in use, `ins_ready` is low and all three insert commands are ignored.
- R13: The output sends at most one sequence number per cycle. It holds `out_valid` and `out_seq` steady while `out_ready` is low. Replayed entries go before pending entries, and pending entries go lowest slot first.
- R14: After reset the table is empty, both barriers are disarmed, `out_valid` is low and `ins_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code (0 to 8) |
| cmd_seq | input | SEQ_W | Sequence number the command refers to, or squash limit S |
| cmd_tid | input | TID_W | Thread of an insert or squash |
| cmd_kind | input | 2 | 0 load, 1 store, 2 full barrier, 3 write barrier |
| cmd_regs_rdy | input | 1 | Registers already ready at insert |
| cmd_pred_seq | input | SEQ_W | Predicted producing store, 0 for none |
| ins_ready | output | 1 | A free slot exists |
| out_valid | output | 1 | Ready sequence number presented |
| out_seq | output | SEQ_W | Issue-ready sequence number |
| out_ready | input | 1 | Consumer accepts the output |

## Verification
The bench builds the block with four slots, 8-bit sequence numbers and two threads. With only four slots, a few inserts fill the table, so the full-table refusal and slot reuse after completion can be tested directly. The squash limit is swept across every boundary of a full table, and the expected survivors are computed from the sequence arithmetic. The small table also makes the three-deep replay ordering, the barrier flags being disarmed one at a time, and output backpressure short enough to run one after another.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

  typedef enum logic [3:0] {
    OP_INS     = 4'd0,
    OP_INS_NS  = 4'd1,
    OP_INS_BAR = 4'd2,
    OP_REGS    = 4'd3,
    OP_NS_RDY  = 4'd4,
    OP_RESCHED = 4'd5,
    OP_REPLAY  = 4'd6,
    OP_DONE    = 4'd7,
    OP_SQUASH  = 4'd8
  } md_op_e;

  typedef enum logic [1:0] {
    K_LOAD    = 2'd0,
    K_STORE   = 2'd1,
    K_FULLBAR = 2'd2,
    K_WRBAR   = 2'd3
  } md_kind_e;

endpackage

// File: rtl/memdep_barrier_trk.sv
module memdep_barrier_trk #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_full,
  input  logic             set_wr,
  input  logic [SEQ_W-1:0] set_seq,
  input  logic             clr_full,
  input  logic             clr_wr,
  input  logic [SEQ_W-1:0] clr_seq,
  output logic             ld_act,
  output logic [SEQ_W-1:0] ld_seq,
  output logic             st_act,
  output logic [SEQ_W-1:0] st_seq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_act <= 1'b0;
      st_act <= 1'b0;
      ld_seq <= '0;
      st_seq <= '0;
    end else if (set_full) begin
      ld_act <= 1'b1;
      ld_seq <= set_seq;
      st_act <= 1'b1;
      st_seq <= set_seq;
    end else if (set_wr) begin
      st_act <= 1'b1;
      st_seq <= set_seq;
    end else begin
      if (clr_full && ld_act && ld_seq == clr_seq) ld_act <= 1'b0;
      if ((clr_full || clr_wr) && st_act && st_seq == clr_seq) st_act <= 1'b0;
    end
  end

  assert_fullbar_arms_both_R4: assert property (@(posedge clk) disable iff (rst)
    set_full |=> (ld_act && st_act && ld_seq == $past(set_seq) && st_seq == $past(set_seq)))
    else $error("full barrier did not arm both flags");

  assert_wrbar_spares_load_R4: assert property (@(posedge clk) disable iff (rst)
    (set_wr && !set_full) |=> (st_act && ld_act == $past(ld_act)))
    else $error("write barrier disturbed load barrier");

  assert_clear_needs_match_R5: assert property (@(posedge clk) disable iff (rst)
    (st_act && st_seq != clr_seq) |=> st_act)
    else $error("store barrier cleared by a foreign number");

endmodule

// File: rtl/memdep_replay_order.sv
module memdep_replay_order #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] push,
  input  logic [N-1:0] pop,
  input  logic [N-1:0] clr,
  input  logic         go,
  output logic [N-1:0] cand
);

  logic [N-1:0] in_rp;
  logic [N-1:0] drain;
  logic [N-1:0] older [N];   // older[j][i]: j joined the list before i

  always_ff @(posedge clk) begin
    if (rst) begin
      in_rp <= '0;
      drain <= '0;
      for (int j = 0; j < N; j++) older[j] <= '0;
    end else begin
      if (go) drain <= in_rp;
      for (int i = 0; i < N; i++) begin
        if (clr[i] || pop[i]) begin
          in_rp[i] <= 1'b0;
          drain[i] <= 1'b0;
        end else if (push[i] && !in_rp[i]) begin
          in_rp[i] <= 1'b1;
          for (int j = 0; j < N; j++) begin
            older[j][i] <= in_rp[j];
            older[i][j] <= 1'b0;
          end
        end
      end
    end
  end

  logic [N-1:0] live;
  assign live = drain & in_rp;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] col;
      for (int j = 0; j < N; j++) col[j] = older[j][i];
      cand[i] = live[i] && ((col & live) == '0);
    end
  end

  assert_one_oldest_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cand))
    else $error("more than one replay head");

  assert_pop_was_listed_R10: assert property (@(posedge clk) disable iff (rst)
    (pop != '0) |-> ((pop & ~in_rp) == '0))
    else $error("replay pop of an unlisted slot");

endmodule

// File: rtl/memdep_out_arb.sv
module memdep_out_arb #(
  parameter int N     = 8,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     rp_cand,
  input  logic [SEQ_W-1:0] slot_seq [N],
  input  logic             allow,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SEQ_W-1:0] out_seq,
  output logic [N-1:0]     take,
  output logic             take_rp
);

  logic [N-1:0]     pend_low;
  logic [N-1:0]     pick;
  logic [SEQ_W-1:0] pick_seq;
  logic             use_rp;
  logic             load;

  assign pend_low = pend & (~pend + N'(1));
  assign use_rp   = |rp_cand;
  assign pick     = use_rp ? rp_cand : pend_low;
  assign load     = allow && (|pick) && (!out_valid || out_ready);
  assign take     = load ? pick : '0;
  assign take_rp  = load && use_rp;

  always_comb begin
    pick_seq = '0;
    for (int i = 0; i < N; i++)
      if (pick[i]) pick_seq = pick_seq | slot_seq[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_seq   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_seq   <= pick_seq;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_holds_R13: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seq)))
    else $error("output changed under backpressure");

  assert_single_grant_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take))
    else $error("more than one slot granted");

endmodule

// File: rtl/memdep_sched.sv
module memdep_sched
  import memdep_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int SEQ_W   = 16,
  parameter int THREADS = 2,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [SEQ_W-1:0] cmd_seq,
  input  logic [TID_W-1:0] cmd_tid,
  input  logic [1:0]       cmd_kind,
  input  logic             cmd_regs_rdy,
  input  logic [SEQ_W-1:0] cmd_pred_seq,
  output logic             ins_ready,
  output logic             out_valid,
  output logic [SEQ_W-1:0] out_seq,
  input  logic             out_ready
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // slot state
  logic [ENTRIES-1:0] vld_q, regs_q, memr_q, dep_q, pend_q;
  logic [SEQ_W-1:0]   seq_q  [ENTRIES];
  logic [TID_W-1:0]   tid_q  [ENTRIES];
  md_kind_e           kind_q [ENTRIES];
  logic [IDX_W-1:0]   pidx_q [ENTRIES];

  md_op_e   op;
  md_kind_e kind_in;
  assign op      = md_op_e'(cmd_op);
  assign kind_in = md_kind_e'(cmd_kind);

  assign ins_ready = ~&vld_q;

  logic do_ins, do_ns, do_bar, do_any_ins, do_regs, do_nsr;
  logic do_resched, do_replay, do_done, do_squash;
  assign do_ins     = cmd_valid && op == OP_INS     && ins_ready;
  assign do_ns      = cmd_valid && op == OP_INS_NS  && ins_ready;
  assign do_bar     = cmd_valid && op == OP_INS_BAR && ins_ready;
  assign do_any_ins = do_ins || do_ns || do_bar;
  assign do_regs    = cmd_valid && op == OP_REGS;
  assign do_nsr     = cmd_valid && op == OP_NS_RDY;
  assign do_resched = cmd_valid && op == OP_RESCHED;
  assign do_replay  = cmd_valid && op == OP_REPLAY;
  assign do_done    = cmd_valid && op == OP_DONE;
  assign do_squash  = cmd_valid && op == OP_SQUASH;

  // barrier state
  logic             ld_act, st_act;
  logic [SEQ_W-1:0] ld_seq, st_seq;
  logic             clr_full, clr_wr;

  // lookups
  logic [SEQ_W-1:0]   prod_seq;
  logic [ENTRIES-1:0] hit_vec, pmatch, sq_mask, done_mask, free_mask, wake;
  logic [IDX_W-1:0]   fidx, pidx_new;
  logic               found;
  md_kind_e           hit_kind;

  always_comb begin
    if (kind_in == K_LOAD && ld_act)       prod_seq = ld_seq;
    else if (kind_in == K_STORE && st_act) prod_seq = st_seq;
    else                                   prod_seq = cmd_pred_seq;
  end

  always_comb begin
    hit_kind = K_LOAD;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = vld_q[i] && seq_q[i] == cmd_seq;
      pmatch[i]  = vld_q[i] && prod_seq != '0 && seq_q[i] == prod_seq
                   && kind_q[i] != K_LOAD;
      sq_mask[i] = do_squash && vld_q[i] && tid_q[i] == cmd_tid
                   && seq_q[i] > cmd_seq;
      if (hit_vec[i]) hit_kind = kind_q[i];
    end
  end

  always_comb begin
    fidx     = '0;
    pidx_new = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) fidx = IDX_W'(i);
      if (pmatch[i]) pidx_new = IDX_W'(i);
    end
  end

  assign found     = |pmatch;
  assign done_mask = do_done ? hit_vec : '0;
  assign free_mask = sq_mask | done_mask;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      wake[i] = vld_q[i] && dep_q[i] && free_mask[pidx_q[i]] && !free_mask[i];
  end

  assign clr_full = do_done && (|hit_vec) && hit_kind == K_FULLBAR;
  assign clr_wr   = do_done && (|hit_vec) && hit_kind == K_WRBAR;

  memdep_barrier_trk #(.SEQ_W(SEQ_W)) u_bar (
    .clk      (clk),
    .rst      (rst),
    .set_full (do_bar && kind_in == K_FULLBAR),
    .set_wr   (do_bar && kind_in == K_WRBAR),
    .set_seq  (cmd_seq),
    .clr_full (clr_full),
    .clr_wr   (clr_wr),
    .clr_seq  (cmd_seq),
    .ld_act   (ld_act),
    .ld_seq   (ld_seq),
    .st_act   (st_act),
    .st_seq   (st_seq)
  );

  // output path
  logic [ENTRIES-1:0] rp_cand, take;
  logic               take_rp;

  memdep_replay_order #(.N(ENTRIES)) u_rp (
    .clk  (clk),
    .rst  (rst),
    .push (do_resched ? hit_vec : '0),
    .pop  (take_rp ? take : '0),
    .clr  (free_mask),
    .go   (do_replay),
    .cand (rp_cand)
  );

  memdep_out_arb #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend_q),
    .rp_cand   (rp_cand),
    .slot_seq  (seq_q),
    .allow     (!do_squash),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_seq   (out_seq),
    .take      (take),
    .take_rp   (take_rp)
  );

  // slot update
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      regs_q <= '0;
      memr_q <= '0;
      dep_q  <= '0;
      pend_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        seq_q[i]  <= '0;
        tid_q[i]  <= '0;
        kind_q[i] <= K_LOAD;
        pidx_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (free_mask[i]) begin
          vld_q[i]  <= 1'b0;
          regs_q[i] <= 1'b0;
          memr_q[i] <= 1'b0;
          dep_q[i]  <= 1'b0;
          pend_q[i] <= 1'b0;
        end else if (do_any_ins && fidx == IDX_W'(i)) begin
          vld_q[i]  <= 1'b1;
          seq_q[i]  <= cmd_seq;
          tid_q[i]  <= cmd_tid;
          kind_q[i] <= kind_in;
          pidx_q[i] <= pidx_new;
          regs_q[i] <= !do_bar && cmd_regs_rdy;
          dep_q[i]  <= do_ins && found;
          memr_q[i] <= do_ins && !found;
          pend_q[i] <= do_ins && !found && cmd_regs_rdy;
        end else begin
          if (take[i]) pend_q[i] <= 1'b0;
          if (wake[i]) begin
            dep_q[i]  <= 1'b0;
            memr_q[i] <= 1'b1;
            if (regs_q[i]) pend_q[i] <= 1'b1;
          end
          if (do_regs && hit_vec[i]) begin
            regs_q[i] <= 1'b1;
            if (memr_q[i]) pend_q[i] <= 1'b1;
          end
          if (do_nsr && hit_vec[i]) pend_q[i] <= 1'b1;
        end
      end
    end
  end

  assert_full_insert_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    ((&vld_q) && cmd_valid && (cmd_op == 4'd0 || cmd_op == 4'd1 || cmd_op == 4'd2))
    |=> (vld_q == $past(vld_q)))
    else $error("insert accepted into a full table");

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    assert_squash_younger_gone_R9: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_op == 4'd8)
      |=> !(vld_q[g] && tid_q[g] == $past(cmd_tid) && seq_q[g] > $past(cmd_seq)))
      else $error("younger entry survived squash");

    assert_wake_ready_sends_R7: assert property (@(posedge clk) disable iff (rst)
      (wake[g] && regs_q[g]) |=> pend_q[g])
      else $error("released entry with ready registers not queued");
  end

endmodule

// File: tb/memdep_sched_test.sv
module memdep_sched_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [7:0] cmd_seq = '0;
  logic [0:0] cmd_tid = '0;
  logic [1:0] cmd_kind = '0;
  logic       cmd_regs_rdy = 1'b0;
  logic [7:0] cmd_pred_seq = '0;
  logic       ins_ready;
  logic       out_valid;
  logic [7:0] out_seq;
  logic       out_ready = 1'b1;

  int vectors = 0;
  int fails   = 0;
  int log_q [0:63];
  int log_n = 0;

  always #5 clk = ~clk;

  memdep_sched #(.ENTRIES(4), .SEQ_W(8), .THREADS(2)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_seq(cmd_seq), .cmd_tid(cmd_tid), .cmd_kind(cmd_kind),
    .cmd_regs_rdy(cmd_regs_rdy), .cmd_pred_seq(cmd_pred_seq),
    .ins_ready(ins_ready), .out_valid(out_valid), .out_seq(out_seq),
    .out_ready(out_ready)
  );

  always @(negedge clk)
    if (!rst && out_valid && out_ready && log_n < 64) begin
      log_q[log_n] = int'(out_seq);
      log_n++;
    end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_log(input string req, input int n,
                            input int a, input int b, input int c, input int d);
    int e [4];
    e[0] = a; e[1] = b; e[2] = c; e[3] = d;
    idle(4);
    check({req, " count"}, log_n, n);
    for (int k = 0; k < n && k < log_n; k++) check(req, log_q[k], e[k]);
    log_n = 0;
  endtask

  task automatic send(input int op, input int sq, input int tid, input int kind,
                      input int regs, input int pred);
    cmd_valid    = 1'b1;
    cmd_op       = 4'(op);
    cmd_seq      = 8'(sq);
    cmd_tid      = 1'(tid);
    cmd_kind     = 2'(kind);
    cmd_regs_rdy = (regs != 0);
    cmd_pred_seq = 8'(pred);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic ld(input int sq, input int regs, input int pred);
    send(0, sq, 0, 0, regs, pred);
  endtask
  task automatic st(input int sq, input int regs, input int pred);
    send(0, sq, 0, 1, regs, pred);
  endtask
  task automatic done(input int sq);
    send(7, sq, 0, 0, 0, 0);
  endtask
  task automatic rr(input int sq);
    send(3, sq, 0, 0, 0, 0);
  endtask

  task automatic do_reset;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    log_n = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R14 reset state
    check("R14 out_valid", int'(out_valid), 0);
    check("R14 ins_ready", int'(ins_ready), 1);

    // R3 no dependence, registers ready
    ld(10, 1, 0);
    expect_log("R3 immediate send", 1, 10, 0, 0, 0);
    // R8 register-ready after memory-ready
    ld(11, 0, 0);
    expect_log("R8 waits for registers", 0, 0, 0, 0, 0);
    rr(11);
    expect_log("R8 send on registers", 1, 11, 0, 0, 0);

    // R6 R7 release by store completion
    do_reset();
    st(20, 1, 0);
    ld(21, 1, 20);
    expect_log("R6 dependent held", 1, 20, 0, 0, 0);
    done(20);
    expect_log("R6 R7 released", 1, 21, 0, 0, 0);
    // R2 absent producer
    ld(22, 1, 99);
    expect_log("R2 absent producer", 1, 22, 0, 0, 0);

    // R7 release without ready registers
    do_reset();
    st(30, 1, 0);
    ld(31, 0, 30);
    done(30);
    expect_log("R7 only memory-ready", 1, 30, 0, 0, 0);
    rr(31);
    expect_log("R7 later send", 1, 31, 0, 0, 0);

    // R8 register-ready before release does not send
    do_reset();
    st(40, 1, 0);
    ld(41, 0, 40);
    rr(41);
    expect_log("R8 not memory-ready", 1, 40, 0, 0, 0);
    done(40);
    expect_log("R8 send at release", 1, 41, 0, 0, 0);

    // R2 a load is never a producer
    do_reset();
    ld(50, 1, 0);
    ld(51, 1, 50);
    expect_log("R2 load producer ignored", 2, 50, 51, 0, 0);

    // R1 R4 R5 full barrier
    do_reset();
    send(2, 60, 0, 2, 0, 0);
    ld(61, 1, 0);
    st(62, 1, 0);
    expect_log("R4 full barrier holds both", 0, 0, 0, 0, 0);
    done(60);
    expect_log("R5 R13 barrier release order", 2, 61, 62, 0, 0);
    ld(63, 1, 0);
    expect_log("R5 barrier disarmed", 1, 63, 0, 0, 0);

    // R4 write barrier
    do_reset();
    send(2, 70, 0, 3, 0, 0);
    ld(71, 1, 0);
    st(72, 1, 0);
    expect_log("R4 write barrier spares loads", 1, 71, 0, 0, 0);
    done(70);
    expect_log("R4 write barrier release", 1, 72, 0, 0, 0);

    // R1 barrier overrides prediction
    do_reset();
    st(80, 1, 0);
    send(2, 81, 0, 2, 0, 0);
    ld(82, 1, 80);
    done(80);
    expect_log("R1 prediction overridden", 1, 80, 0, 0, 0);
    done(81);
    expect_log("R1 barrier producer", 1, 82, 0, 0, 0);

    // R5 selective disarm
    do_reset();
    send(2, 90, 0, 2, 0, 0);
    send(2, 91, 0, 3, 0, 0);
    done(90);
    ld(93, 1, 0);
    st(94, 1, 0);
    expect_log("R5 load barrier cleared, store kept", 1, 93, 0, 0, 0);
    done(91);
    expect_log("R5 store barrier release", 1, 94, 0, 0, 0);

    // R9 squash by thread and number
    do_reset();
    send(0, 100, 0, 0, 0, 0);
    send(0, 101, 0, 0, 0, 0);
    send(0, 102, 1, 0, 0, 0);
    send(8, 100, 0, 0, 0, 0);
    rr(101);
    rr(100);
    rr(102);
    expect_log("R9 squash survivors", 2, 100, 102, 0, 0);

    // R9 squashed dependent is not released
    do_reset();
    st(110, 1, 0);
    ld(111, 1, 110);
    send(8, 110, 0, 0, 0, 0);
    done(110);
    expect_log("R9 squashed dependent", 1, 110, 0, 0, 0);
    check("R9 slots freed", int'(ins_ready), 1);

    // R10 replay order and squash of the list
    do_reset();
    ld(120, 1, 0);
    ld(121, 1, 0);
    ld(122, 1, 0);
    expect_log("R10 initial sends", 3, 120, 121, 122, 0);
    send(5, 122, 0, 0, 0, 0);
    send(5, 120, 0, 0, 0, 0);
    send(5, 121, 0, 0, 0, 0);
    expect_log("R10 reschedule sends nothing", 0, 0, 0, 0, 0);
    send(6, 0, 0, 0, 0, 0);
    expect_log("R10 replay order", 3, 122, 120, 121, 0);
    send(5, 121, 0, 0, 0, 0);
    send(5, 122, 0, 0, 0, 0);
    send(8, 121, 0, 0, 0, 0);
    send(6, 0, 0, 0, 0, 0);
    expect_log("R10 squashed replay entry dropped", 1, 121, 0, 0, 0);

    // R11 non-speculative
    do_reset();
    send(1, 130, 0, 0, 1, 0);
    rr(130);
    expect_log("R11 no send before command", 0, 0, 0, 0, 0);
    send(4, 130, 0, 0, 0, 0);
    expect_log("R11 send on command", 1, 130, 0, 0, 0);

    // R12 full table
    do_reset();
    for (int s = 1; s <= 4; s++) ld(s, 0, 0);
    check("R12 ins_ready low", int'(ins_ready), 0);
    ld(5, 1, 0);
    rr(5);
    expect_log("R12 insert ignored", 0, 0, 0, 0, 0);
    done(1);
    check("R12 slot reusable", int'(ins_ready), 1);

    // R13 backpressure
    do_reset();
    out_ready = 1'b0;
    ld(140, 1, 0);
    ld(141, 1, 0);
    ld(142, 1, 0);
    idle(2);
    check("R13 valid under stall", int'(out_valid), 1);
    check("R13 first held", int'(out_seq), 140);
    idle(3);
    check("R13 still held", int'(out_seq), 140);
    out_ready = 1'b1;
    expect_log("R13 drain order", 3, 140, 141, 142, 0);

    // R9 sweep of the squash limit over a full table
    for (int k = 0; k <= 4; k++) begin
      do_reset();
      for (int s = 0; s < 4; s++) ld(200 + s, 0, 0);
      send(8, 199 + k, 0, 0, 0, 0);
      check("R9 sweep free slot", int'(ins_ready), (k < 4) ? 1 : 0);
      for (int s = 0; s < 4; s++) rr(200 + s);
      expect_log("R9 sweep survivors", k, 200, 201, 202, 203);
    end

    finish_run();
  end

endmodule